// File: doc/BRIEF.md
# Two-Stride Pattern Prefetcher

This block watches a single stream of demand cache-block addresses and predicts the next block from it. It learns two forms of regular access. In the first, every step has the same stride. In the second, a short stride repeats a fixed number of times and is then followed by one longer jump. Once the prediction is trusted, the block issues one prefetch block address per demand. The prefetch appears in the cycle after the demand that triggers it.

A small table holds the blocks that have a prefetch in flight. A prediction that matches a block in this table is merged and not sent again. A prediction for a block that is being demanded in that same cycle is also merged. A 2-bit confidence counter decides whether a learned pattern may issue prefetches, and it drops the pattern when the stream stops following it. Three counters report issued, useful and covered prefetches. They ignore a warm-up period at the start of the stream.

Top module: `twodelta_prefetcher`

## Requirements
- R1: During and after reset, `pf_valid` is 0 and all three statistics counters read 0.
- R2: While no two-stride pattern is learned, a demand whose address sits at the same non-zero stride S from the previous demand as that one did from the demand before it triggers a prefetch of address+S. The first two demands of a stream never trigger a prefetch.
- R3: While untrained, the first non-zero stride seen becomes the short stride D1. A later stride other than D1 becomes the long stride D2, and the number of consecutive D1 steps before it becomes the repeat count N. The confidence is set to 2, and the block prefetches address+D1.
- R4: Once trained, the prediction after a demand is address+D1 while fewer than N D1 steps have followed the last D2 step, and address+D2 otherwise. On the pattern 0x100, 0x101, 0x102, 0x107, ... the block learns D1=1, D2=5 and N=2.
- R5: Each prefetch is presented for one cycle, in the cycle right after the demand that triggers it. A demand triggers at most one prefetch.
- R6: The confidence counter saturates at 3. It rises when a demand equals the prediction and falls on any other non-zero-stride demand. A trained prediction is issued only when the updated confidence is 2 or more.
- R7: When a miss brings the confidence to 0, D1, D2 and N are discarded. Learning restarts with that demand as the first address, and the single-stride mode of R2 applies again.
- R8: A predicted block that is already held in the 4-entry in-flight table, or that is being demanded in the issue cycle, is not issued.
- R9: An in-flight entry is freed by a demand or a fill to its block, so a later prediction of that block is issued again.
- R10: The first six demands after reset are not counted. Counting then works as follows: issued counts prefetches triggered by a counted demand; useful counts counted demands found in the in-flight table; covered counts counted demands that equal the trained prediction.
- R11: On the pattern of R4, every demand from the seventh onward is covered and useful, and each one adds exactly one issued prefetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | Demand access strobe |
| dmd_addr | input | AW | Demand block address |
| fill_valid | input | 1 | Fill arrival strobe |
| fill_addr | input | AW | Filled block address |
| pf_valid | output | 1 | Prefetch issue strobe |
| pf_addr | output | AW | Prefetch block address |
| cnt_issued | output | CNTW | Issued prefetches after warm-up |
| cnt_useful | output | CNTW | Demands served by an in-flight prefetch |
| cnt_covered | output | CNTW | Demands matching the trained prediction |

## Verification
The assertions hold on every cycle. A prefetch only follows a demand by one cycle. An issued block never duplicates a live in-flight entry or the block being demanded in that cycle. Each statistics counter only steps by one, and only after the event it counts. The bench scenarios are the only place where the learned values of D1, D2 and N, the exact predicted addresses, the confidence thresholds and the retraining after a loss of confidence can be seen. The same holds for freeing by fill, and for the exact counts after warm-up on the repeating pattern.

// File: rtl/pf_pkg.sv
// Shared constants for the two-stride prefetcher.
// Assumes a 2-bit confidence counter and a fixed warm-up length.
package pf_pkg;
    localparam int          CONF_W     = 2;
    localparam logic [1:0]  CONF_MAX   = 2'd3;
    localparam logic [1:0]  CONF_ISSUE = 2'd2;
    localparam logic [1:0]  CONF_INIT  = 2'd2;
    localparam int          WARMUP     = 6;
endpackage

// File: rtl/pf_learner.sv
// Stride learner and predictor.
// It learns a single stride, or a short stride D1 taken N times followed by
// one long stride D2, and produces a prefetch candidate combinationally for
// each demand. It assumes at most one demand per cycle. Demands at a zero
// stride leave the learner unchanged.
module pf_learner #(
    parameter int AW = 32,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dmd_valid,
    input  logic [AW-1:0] dmd_addr,
    output logic          cand_valid,
    output logic [AW-1:0] cand_addr,
    output logic          covered
);
    import pf_pkg::*;

    localparam logic [RW-1:0] RUN_MAX = {RW{1'b1}};

    logic              have_last, have_d1, trained;
    logic [AW-1:0]     last_addr, d1, d2, pred;
    logic [RW-1:0]     run, nrep, pos;
    logic [CONF_W-1:0] conf;

    logic              n_have_last, n_have_d1, n_trained;
    logic [AW-1:0]     n_last_addr, n_d1, n_d2, n_pred, delta, target;
    logic [RW-1:0]     n_run, n_nrep, n_pos;
    logic [CONF_W-1:0] n_conf;
    logic              step, hit;

    assign delta   = dmd_addr - last_addr;
    assign step    = dmd_valid && have_last && (delta != '0);
    assign hit     = trained && (dmd_addr == pred);
    assign covered = dmd_valid && hit;

    // Next-state: learning, confidence tracking and candidate generation.
    always_comb begin
        n_have_last = have_last;  n_have_d1 = have_d1;  n_trained = trained;
        n_last_addr = last_addr;  n_d1 = d1;  n_d2 = d2;  n_pred = pred;
        n_run = run;  n_nrep = nrep;  n_pos = pos;  n_conf = conf;
        cand_valid = 1'b0;
        cand_addr  = '0;
        target     = '0;
        if (dmd_valid && !have_last) begin
            n_have_last = 1'b1;
            n_last_addr = dmd_addr;
        end else if (step) begin
            n_last_addr = dmd_addr;
            if (trained) begin
                n_pos  = (delta == d2) ? '0 : ((pos == RUN_MAX) ? pos : pos + 1'b1);
                n_conf = hit ? ((conf == CONF_MAX) ? conf : conf + 1'b1) : conf - 1'b1;
                if (!hit && conf == 2'd1) begin
                    n_trained = 1'b0;
                    n_have_d1 = 1'b0;
                    n_conf    = '0;
                end else begin
                    target     = (n_pos < nrep) ? dmd_addr + d1 : dmd_addr + d2;
                    n_pred     = target;
                    cand_valid = (n_conf >= CONF_ISSUE);
                    cand_addr  = target;
                end
            end else if (!have_d1) begin
                n_have_d1 = 1'b1;
                n_d1      = delta;
                n_run     = 1;
            end else if (delta == d1) begin
                n_run      = (run == RUN_MAX) ? run : run + 1'b1;
                cand_valid = 1'b1;
                cand_addr  = dmd_addr + delta;
            end else begin
                n_trained  = 1'b1;
                n_d2       = delta;
                n_nrep     = run;
                n_pos      = '0;
                n_conf     = CONF_INIT;
                n_pred     = dmd_addr + d1;
                cand_valid = 1'b1;
                cand_addr  = dmd_addr + d1;
            end
        end
    end

    // State update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_last <= 1'b0;  have_d1 <= 1'b0;  trained <= 1'b0;
            last_addr <= '0;  d1 <= '0;  d2 <= '0;  pred <= '0;
            run <= '0;  nrep <= '0;  pos <= '0;  conf <= '0;
        end else begin
            have_last <= n_have_last;  have_d1 <= n_have_d1;  trained <= n_trained;
            last_addr <= n_last_addr;  d1 <= n_d1;  d2 <= n_d2;  pred <= n_pred;
            run <= n_run;  nrep <= n_nrep;  pos <= n_pos;  conf <= n_conf;
        end
    end
endmodule

// File: rtl/pf_inflight.sv
// Table of blocks with a prefetch in flight.
// It looks up the issue candidate and the current demand. An entry is freed
// by a demand or a fill to its block. It allocates into the lowest free
// entry, or round-robin when the table is full. It assumes the allocated
// address is never already present.
module pf_inflight #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_v,
    input  logic [AW-1:0]         alloc_addr,
    input  logic [AW-1:0]         look_addr,
    input  logic                  dmd_valid,
    input  logic [AW-1:0]         dmd_addr,
    input  logic                  fill_valid,
    input  logic [AW-1:0]         fill_addr,
    output logic                  look_hit,
    output logic                  dmd_hit,
    output logic [DEPTH-1:0]      ent_v,
    output logic [DEPTH*AW-1:0]   ent_a
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0] look_m, dmd_m, fill_m;
    logic [IW-1:0]    rr_ptr, free_idx, alloc_idx;
    logic             any_free;

    // Per-entry match logic.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign look_m[i] = ent_v[i] && (ent_a[i*AW +: AW] == look_addr);
        assign dmd_m[i]  = ent_v[i] && dmd_valid  && (ent_a[i*AW +: AW] == dmd_addr);
        assign fill_m[i] = ent_v[i] && fill_valid && (ent_a[i*AW +: AW] == fill_addr);
    end

    assign look_hit = |look_m;
    assign dmd_hit  = |dmd_m;

    // Lowest free entry search.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!ent_v[i]) begin
                any_free = 1'b1;
                free_idx = IW'(i);
            end
        end
        alloc_idx = any_free ? free_idx : rr_ptr;
    end

    // Entry valid bits, addresses and the round-robin pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v  <= '0;
            ent_a  <= '0;
            rr_ptr <= '0;
        end else begin
            ent_v <= ent_v & ~(dmd_m | fill_m);
            if (alloc_v) begin
                ent_v[alloc_idx]            <= 1'b1;
                ent_a[alloc_idx*AW +: AW]   <= alloc_addr;
                if (!any_free)
                    rr_ptr <= (rr_ptr == IW'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pf_stats.sv
// Prefetch statistics counters.
// Counting starts after the warm-up demands; the counters saturate at all ones.
module pf_stats #(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dmd_valid,
    input  logic            issue_cnt,
    input  logic            useful_ev,
    input  logic            covered_ev,
    output logic            stat_on,
    output logic [CNTW-1:0] cnt_issued,
    output logic [CNTW-1:0] cnt_useful,
    output logic [CNTW-1:0] cnt_covered
);
    import pf_pkg::*;

    localparam int SW = $clog2(WARMUP + 1);
    localparam logic [CNTW-1:0] CMAX = {CNTW{1'b1}};

    logic [SW-1:0] seen;

    assign stat_on = (seen == SW'(WARMUP));

    // Warm-up demand count and the three event counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen        <= '0;
            cnt_issued  <= '0;
            cnt_useful  <= '0;
            cnt_covered <= '0;
        end else begin
            if (dmd_valid && !stat_on) seen <= seen + 1'b1;
            if (issue_cnt && cnt_issued != CMAX)                          cnt_issued  <= cnt_issued + 1'b1;
            if (useful_ev && stat_on && dmd_valid && cnt_useful != CMAX)  cnt_useful  <= cnt_useful + 1'b1;
            if (covered_ev && stat_on && cnt_covered != CMAX)             cnt_covered <= cnt_covered + 1'b1;
        end
    end
endmodule

// File: rtl/twodelta_prefetcher.sv
// Top of the two-stride prefetcher.
// A learner produces a candidate per demand. The candidate is registered and
// issued in the next cycle unless it is merged with an in-flight block or the
// concurrent demand. Issued blocks enter the in-flight table.
module twodelta_prefetcher #(
    parameter int AW    = 32,
    parameter int RW    = 4,
    parameter int DEPTH = 4,
    parameter int CNTW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dmd_valid,
    input  logic [AW-1:0]   dmd_addr,
    input  logic            fill_valid,
    input  logic [AW-1:0]   fill_addr,
    output logic            pf_valid,
    output logic [AW-1:0]   pf_addr,
    output logic [CNTW-1:0] cnt_issued,
    output logic [CNTW-1:0] cnt_useful,
    output logic [CNTW-1:0] cnt_covered
);
    logic                cand_valid, covered, stat_on, look_hit, dmd_hit;
    logic [AW-1:0]       cand_addr;
    logic                cq_v, cq_stat;
    logic [AW-1:0]       cq_addr;
    logic [DEPTH-1:0]    ent_v;
    logic [DEPTH*AW-1:0] ent_a;

    pf_learner #(.AW(AW), .RW(RW)) u_learn (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .cand_valid(cand_valid), .cand_addr(cand_addr), .covered(covered)
    );

    // Candidate stage: holds the candidate for issue in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq_v    <= 1'b0;
            cq_stat <= 1'b0;
            cq_addr <= '0;
        end else begin
            cq_v    <= cand_valid;
            cq_stat <= stat_on;
            cq_addr <= cand_addr;
        end
    end

    assign pf_valid = cq_v && !look_hit && !(dmd_valid && dmd_addr == cq_addr);
    assign pf_addr  = cq_addr;

    pf_inflight #(.AW(AW), .DEPTH(DEPTH)) u_tbl (
        .clk(clk), .rst_n(rst_n), .alloc_v(pf_valid), .alloc_addr(cq_addr),
        .look_addr(cq_addr), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .look_hit(look_hit), .dmd_hit(dmd_hit), .ent_v(ent_v), .ent_a(ent_a)
    );

    pf_stats #(.CNTW(CNTW)) u_stats (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid),
        .issue_cnt(pf_valid && cq_stat), .useful_ev(dmd_hit), .covered_ev(covered),
        .stat_on(stat_on), .cnt_issued(cnt_issued), .cnt_useful(cnt_useful),
        .cnt_covered(cnt_covered)
    );
endmodule

// File: rtl/pf_checker.sv
// Cycle-level properties of the prefetcher, attached by bind.
module pf_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 4,
    parameter int CNTW  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dmd_valid,
    input logic [AW-1:0]       dmd_addr,
    input logic                pf_valid,
    input logic [AW-1:0]       pf_addr,
    input logic [CNTW-1:0]     cnt_issued,
    input logic [CNTW-1:0]     cnt_useful,
    input logic [CNTW-1:0]     cnt_covered,
    input logic [DEPTH-1:0]    ent_v,
    input logic [DEPTH*AW-1:0] ent_a
);
    p_issue_after_demand_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(dmd_valid));

    p_not_same_demand_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && dmd_valid) |-> (pf_addr != dmd_addr));

    for (genvar i = 0; i < DEPTH; i++) begin : g_nodup
        p_no_dup_inflight_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pf_valid |-> !(ent_v[i] && ent_a[i*AW +: AW] == pf_addr));
    end

    p_issued_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_issued != $past(cnt_issued)) |-> ($past(pf_valid) && cnt_issued == $past(cnt_issued) + 1'b1));

    p_useful_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_useful != $past(cnt_useful)) |-> ($past(dmd_valid) && cnt_useful == $past(cnt_useful) + 1'b1));

    p_covered_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_covered != $past(cnt_covered)) |-> ($past(dmd_valid) && cnt_covered == $past(cnt_covered) + 1'b1));
endmodule

bind twodelta_prefetcher pf_checker #(.AW(AW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .cnt_issued(cnt_issued),
    .cnt_useful(cnt_useful), .cnt_covered(cnt_covered), .ent_v(ent_v), .ent_a(ent_a)
);

// File: tb/twodelta_prefetcher_tb_top.sv
// Scoreboard bench: the driver queues expected prefetches and the monitor matches them.
module twodelta_prefetcher_tb_top;
    localparam int AW = 32;
    localparam int CNTW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dmd_valid = 1'b0;
    logic [AW-1:0]   dmd_addr = '0;
    logic            fill_valid = 1'b0;
    logic [AW-1:0]   fill_addr = '0;
    logic            pf_valid;
    logic [AW-1:0]   pf_addr;
    logic [CNTW-1:0] cnt_issued, cnt_useful, cnt_covered;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [AW-1:0] q_addr[$];
    int            q_cyc[$];
    string         q_req[$];

    twodelta_prefetcher #(.AW(AW), .CNTW(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_addr(dmd_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .pf_valid(pf_valid),
        .pf_addr(pf_addr), .cnt_issued(cnt_issued), .cnt_useful(cnt_useful),
        .cnt_covered(cnt_covered)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare issued prefetches against the expected queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
                chk(0, {q_req[0], " missing prefetch"}, 0, q_addr[0]);
                void'(q_addr.pop_front()); void'(q_cyc.pop_front()); void'(q_req.pop_front());
            end
            if (pf_valid) begin
                if (q_cyc.size() == 0 || q_cyc[0] != cyc) begin
                    chk(0, "R8 unexpected prefetch", pf_addr, 0);
                end else begin
                    chk(pf_addr == q_addr[0], q_req[0], pf_addr, q_addr[0]);
                    void'(q_addr.pop_front()); void'(q_cyc.pop_front()); void'(q_req.pop_front());
                end
            end
        end
    end

    // Driver: one demand pulse, with an optional expected prefetch a cycle later.
    task automatic demand(input logic [AW-1:0] a, input bit exp_pf, input logic [AW-1:0] ea, input string req);
        @(posedge clk); #1;
        dmd_valid = 1'b1; dmd_addr = a;
        if (exp_pf) begin
            q_addr.push_back(ea); q_cyc.push_back(cyc + 1); q_req.push_back(req);
        end
        @(posedge clk); #1;
        dmd_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic fill(input logic [AW-1:0] a);
        @(posedge clk); #1;
        fill_valid = 1'b1; fill_addr = a;
        @(posedge clk); #1;
        fill_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic drain(input string req);
        repeat (4) @(posedge clk);
        chk(q_cyc.size() == 0, req, q_cyc.size(), 0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pf_valid == 1'b0, "R1 pf_valid", pf_valid, 0);
        chk(cnt_issued == 0 && cnt_useful == 0 && cnt_covered == 0, "R1 counters",
            cnt_issued + cnt_useful + cnt_covered, 0);
        #1 rst_n = 1'b1;

        // R2 R3 R4 R5 R11: learning D1=1, D2=5, N=2
        demand(32'h100, 0, 0,        "R2");
        demand(32'h101, 0, 0,        "R2");
        demand(32'h102, 1, 32'h103,  "R2 basic stride");
        demand(32'h107, 1, 32'h108,  "R3 learn D2");
        demand(32'h108, 1, 32'h109,  "R4 D1 step");
        demand(32'h109, 1, 32'h10E,  "R4 D2 step");
        demand(32'h10E, 1, 32'h10F,  "R11");
        demand(32'h10F, 1, 32'h110,  "R11");
        demand(32'h110, 1, 32'h115,  "R11");
        demand(32'h115, 1, 32'h116,  "R11");
        demand(32'h116, 1, 32'h117,  "R11");
        demand(32'h117, 1, 32'h11C,  "R11");
        demand(32'h11C, 1, 32'h11D,  "R5 R11");
        drain("R5 queue empty");
        @(negedge clk);
        chk(cnt_issued == 7,  "R10 R11 issued",  cnt_issued, 7);
        chk(cnt_useful == 7,  "R10 R11 useful",  cnt_useful, 7);
        chk(cnt_covered == 7, "R10 R11 covered", cnt_covered, 7);

        // R6 R7: confidence decay, discard and retraining
        demand(32'h130, 1, 32'h131, "R6 issue at conf 2");
        demand(32'h140, 0, 0,       "R6 no issue at conf 1");
        demand(32'h150, 0, 0,       "R7 discard");
        demand(32'h151, 0, 0,       "R7 first stride");
        demand(32'h152, 1, 32'h153, "R7 basic after retrain");
        demand(32'h157, 1, 32'h158, "R7 R3 relearn");
        drain("R6 R7 queue empty");

        // R8: merge with an in-flight block
        do_reset();
        demand(32'h500, 0, 0,       "R8");
        demand(32'h501, 0, 0,       "R8");
        demand(32'h502, 1, 32'h503, "R8 basic");
        demand(32'h501, 1, 32'h502, "R8 learn D2=-1");
        demand(32'h502, 0, 0,       "R8 merged 503");
        drain("R8 queue empty");

        // R9: a fill frees the entry
        do_reset();
        demand(32'h500, 0, 0,       "R9");
        demand(32'h501, 0, 0,       "R9");
        demand(32'h502, 1, 32'h503, "R9 basic");
        fill(32'h503);
        demand(32'h501, 1, 32'h502, "R9 learn");
        demand(32'h502, 1, 32'h503, "R9 reissued after fill");
        drain("R9 queue empty");

        // R2: constant stride 3
        do_reset();
        demand(32'h600, 0, 0,       "R2 first");
        demand(32'h603, 0, 0,       "R2 second");
        demand(32'h606, 1, 32'h609, "R2 stride 3");
        demand(32'h609, 1, 32'h60C, "R2 stride 3 again");
        drain("R2 queue empty");
        @(negedge clk);
        chk(cnt_issued == 0, "R10 warm-up excluded", cnt_issued, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule